// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a clocked static RAM with registered read data, a four-word burst address counter and per-byte write lanes. Every address and control input is captured on the rising clock edge. An access begins when one of two address strobes loads an external address. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, depending on the write controls. On later cycles an advance input either steps the burst counter or holds the current address, which inserts wait states. The output enable is not clocked and only gates the data bus drive.

The bidirectional data bus is split into an input bus, an output bus and an output-drive flag. A surrounding pad ring or bus model merges these. The word is split into byte lanes of nine bits: eight data bits plus one parity bit. The word width, lane count and address width are parameters. The default is a 36-bit word, four lanes and a 64-word array.

Top module: `burst_sram`

## Requirements
- R1: With `ce_n_i` high at an edge, no address is loaded and nothing is written. `dq_oe_o` is low after the following edge.
- R2: With `ce_n_i` low and `pstb_n_i` low at an edge, `addr_i` is loaded and a read begins. This holds even when the write controls are active at that edge, and nothing is written.
- R3: With `ce_n_i` low, `pstb_n_i` high, `cstb_n_i` low and the write controls active, `addr_i` is loaded and the `dq_i` lanes selected by R7/R8 are written at that same edge. No read data is driven for that cycle.
- R4: With `ce_n_i` low, `pstb_n_i` high, `cstb_n_i` low and every write control high, `addr_i` is loaded and read.
- R5: With `ce_n_i` low, both strobes high and `adv_n_i` low, the burst address advances. The low two bits step by one modulo 4, the upper bits are unchanged, and the cycle reads or writes according to the write controls.
- R6: With `ce_n_i` low, both strobes high and `adv_n_i` high, the current burst address is reused for the read or the write.
- R7: `gw_n_i` low marks every lane for writing, whatever `bwe_n_i` and `bw_n_i` hold.
- R8: With `gw_n_i` high, lane i (`dq_i[9i+8:9i]`) is written only when `bwe_n_i` and `bw_n_i[i]` are both low. With `bwe_n_i` high, the cycle is a read.
- R9: `dq_oe_o` is low whenever `oe_n_i` is high. The gating is combinational and not sampled.
- R10: Read data for an address sampled at edge N appears on `dq_o` after edge N+1, with `dq_oe_o` high while `oe_n_i` is low. It holds until the next edge.
- R11: A burst opened by the processor-side strobe is written by a later continue or suspend cycle that has the write controls active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| ce_n_i | input | 1 | Chip enable, active low |
| pstb_n_i | input | 1 | Processor-side address strobe, active low |
| cstb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low; high suspends |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | DATA_W | Write data from the shared bus |
| dq_o | output | DATA_W | Read data toward the shared bus |
| dq_oe_o | output | 1 | Bus drive enable for `dq_o` |

## Verification
The suspend property assumes two things. The cycle before a suspended read was itself a read, and no reset fell inside the window, so the same address is read twice. The stimulus meets this by following each strobe read directly with suspend cycles. The deselect, strobe and write properties assume `oe_n_i` changes only between clock edges. The bench drives it on the falling edge, and it is held low except in the dedicated gating probe. Reads are made only of words written earlier in the run. The bench writes the whole array first, so read data is never undefined.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    localparam int BURST_BITS = 2;

endpackage

// File: rtl/write_lane_decode.sv
module write_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    output logic [LANES-1:0] lane_we_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we_o[g] = !gw_n_i || (!bwe_n_i && !bw_n_i[g]);
    end

endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              pstb_n_i,
    input  logic              cstb_n_i,
    input  logic              adv_n_i,
    input  logic [LANES-1:0]  lane_we_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output acc_kind_e         acc_kind_o,
    output logic [LANES-1:0]  acc_we_o
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    acc_kind_e   kind;
    logic        wr_req;
    logic [BURST_BITS-1:0] low_next;

    always_comb begin
        s_d      = s_q;
        kind     = ACC_IDLE;
        wr_req   = |lane_we_i;
        low_next = s_q.addr[BURST_BITS-1:0] + BURST_BITS'(1);
        if (ce_n_i) begin
            kind = ACC_IDLE;
        end else if (!pstb_n_i) begin
            s_d.addr = addr_i;
            kind     = ACC_READ;
        end else if (!cstb_n_i) begin
            s_d.addr = addr_i;
            kind     = wr_req ? ACC_WRITE : ACC_READ;
        end else begin
            if (!adv_n_i) begin
                s_d.addr = {s_q.addr[ADDR_W-1 -: HI_W], low_next};
            end
            kind = wr_req ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_addr_o = s_d.addr;
    assign acc_kind_o = kind;
    assign acc_we_o   = (kind == ACC_WRITE) ? lane_we_i : '0;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
    end

endmodule

// File: rtl/read_pipe.sv
module read_pipe #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [ADDR_W-1:0] arr_raddr_o,
    input  logic [DATA_W-1:0] arr_rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dvalid_o
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic [DATA_W-1:0] data;
    } pipe_state_t;

    pipe_state_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.pend  = rd_req_i;
        if (rd_req_i) begin
            p_d.addr = rd_addr_i;
        end
        p_d.valid = p_q.pend;
        if (p_q.pend) begin
            p_d.data = arr_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign arr_raddr_o = p_q.addr;
    assign dout_o      = p_q.data;
    assign dvalid_o    = p_q.valid;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              pstb_n_i,
    input  logic              cstb_n_i,
    input  logic              adv_n_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    acc_kind_e         acc_kind;
    logic [LANES-1:0]  acc_we;
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] dout;
    logic              dvalid;

    write_lane_decode #(.LANES(LANES)) u_wdec (
        .gw_n_i    (gw_n_i),
        .bwe_n_i   (bwe_n_i),
        .bw_n_i    (bw_n_i),
        .lane_we_o (lane_we)
    );

    burst_addr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .ce_n_i     (ce_n_i),
        .pstb_n_i   (pstb_n_i),
        .cstb_n_i   (cstb_n_i),
        .adv_n_i    (adv_n_i),
        .lane_we_i  (lane_we),
        .acc_addr_o (acc_addr),
        .acc_kind_o (acc_kind),
        .acc_we_o   (acc_we)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we_i    (acc_we),
        .waddr_i (acc_addr),
        .wdata_i (dq_i),
        .raddr_i (arr_raddr),
        .rdata_o (arr_rdata)
    );

    read_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rpipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (acc_kind == ACC_READ),
        .rd_addr_i   (acc_addr),
        .arr_raddr_o (arr_raddr),
        .arr_rdata_i (arr_rdata),
        .dout_o      (dout),
        .dvalid_o    (dvalid)
    );

    assign dq_o    = dout;
    assign dq_oe_o = dvalid && !oe_n_i;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n_i,
    input logic              pstb_n_i,
    input logic              cstb_n_i,
    input logic              adv_n_i,
    input logic              gw_n_i,
    input logic              bwe_n_i,
    input logic [LANES-1:0]  bw_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o
);

    logic wr_ctl;
    logic rd_now;

    assign wr_ctl = !gw_n_i || (!bwe_n_i && (bw_n_i != {LANES{1'b1}}));
    assign rd_now = !ce_n_i && (!pstb_n_i || !wr_ctl);

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> ##2 !dq_oe_o); // R1

    AST_PSTROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && !pstb_n_i) |-> ##2 (dq_oe_o == !oe_n_i)); // R2

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_i && pstb_n_i && !cstb_n_i && wr_ctl) |-> ##2 !dq_oe_o); // R3

    AST_SUSPEND_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && pstb_n_i && cstb_n_i && adv_n_i && $past(rd_now))
            |-> ##2 (dq_o == $past(dq_o))); // R6

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o); // R9

endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;

    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic              ce_n_i, pstb_n_i, cstb_n_i, adv_n_i, gw_n_i, bwe_n_i, oe_n_i;
    logic [LANES-1:0]  bw_n_i;
    logic [DATA_W-1:0] dq_i;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe_o;

    int checks = 0;
    int fails  = 0;

    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [ADDR_W-1:0] m_addr;
    logic              pend_valid;
    logic [DATA_W-1:0] pend_data;
    string             pend_tag;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
        .pstb_n_i(pstb_n_i), .cstb_n_i(cstb_n_i), .adv_n_i(adv_n_i),
        .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .bw_n_i(bw_n_i), .oe_n_i(oe_n_i),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    function automatic logic [DATA_W-1:0] val(int a, int k);
        return {4'(k), 8'(a), 8'(a ^ 8'h5A), 8'(~a), 8'(a * 3 + k * 7)};
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clocked access; the bench model follows the requirement text.
    task automatic step(logic ce_n, logic ps_n, logic cs_n, logic adv_n,
                        logic gw_n, logic bwe_n, logic [LANES-1:0] bw_n,
                        int a, logic [DATA_W-1:0] wd, string tag);
        logic [LANES-1:0] lw;
        logic             wr, rd, acc;
        ce_n_i = ce_n; pstb_n_i = ps_n; cstb_n_i = cs_n; adv_n_i = adv_n;
        gw_n_i = gw_n; bwe_n_i = bwe_n; bw_n_i = bw_n;
        addr_i = ADDR_W'(a); dq_i = wd;
        for (int i = 0; i < LANES; i++) lw[i] = !gw_n || (!bwe_n && !bw_n[i]);
        wr = |lw; rd = 1'b0; acc = 1'b0;
        if (!ce_n) begin
            acc = 1'b1;
            if (!ps_n) begin
                m_addr = ADDR_W'(a); rd = 1'b1;
            end else if (!cs_n) begin
                m_addr = ADDR_W'(a); rd = !wr;
            end else begin
                if (!adv_n) m_addr = {m_addr[ADDR_W-1:2], m_addr[1:0] + 2'd1};
                rd = !wr;
            end
        end
        if (acc && !rd) begin
            for (int i = 0; i < LANES; i++)
                if (lw[i]) ref_mem[m_addr][i*LANE_W +: LANE_W] = wd[i*LANE_W +: LANE_W];
        end
        @(posedge clk);
        @(negedge clk);
        if (pend_valid) begin
            check({pend_tag, " drive"}, DATA_W'(dq_oe_o), DATA_W'(1));
            check({pend_tag, " data"}, dq_o, pend_data);
        end else begin
            check({pend_tag, " hiz"}, DATA_W'(dq_oe_o), DATA_W'(0));
        end
        pend_valid = rd;
        pend_data  = ref_mem[m_addr];
        pend_tag   = tag;
    endtask

    task automatic idle(string tag);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 0, '0, tag);
    endtask

    task automatic pread(int a, string tag);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, a, '0, tag);
    endtask

    task automatic cwrite(int a, logic gw_n, logic bwe_n, logic [LANES-1:0] bw_n,
                          logic [DATA_W-1:0] wd, string tag);
        step(1'b0, 1'b1, 1'b0, 1'b1, gw_n, bwe_n, bw_n, a, wd, tag);
    endtask

    task automatic cont(logic adv_n, logic gw_n, logic [DATA_W-1:0] wd, string tag);
        step(1'b0, 1'b1, 1'b1, adv_n, gw_n, 1'b1, '1, 0, wd, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n_i = 1'b1; pstb_n_i = 1'b1; cstb_n_i = 1'b1; adv_n_i = 1'b1;
        gw_n_i = 1'b1; bwe_n_i = 1'b1; bw_n_i = '1; oe_n_i = 1'b0; addr_i = '0; dq_i = '0;
        m_addr = '0; pend_valid = 1'b0; pend_data = '0; pend_tag = "R1 reset";
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset drive", DATA_W'(dq_oe_o), DATA_W'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R7: fill every word via controller strobe with global write
        for (int a = 0; a < DEPTH; a++) cwrite(a, 1'b0, 1'b1, '1, val(a, 0), "R3");
        idle("R3");

        // R2 / R5 / R10: strobe read every start offset, then three advances (wraps)
        for (int a = 0; a < DEPTH; a++) begin
            pread(a, "R2");
            for (int k = 0; k < 3; k++) cont(1'b0, 1'b1, '0, "R5");
        end
        idle("R5");

        // R4: controller strobe with write controls high reads
        for (int a = 0; a < DEPTH; a += 5) cwrite(a, 1'b1, 1'b1, 4'b0000, '0, "R4");
        idle("R4");

        // R8: every lane mask via byte-write enable, then read back
        for (int m = 0; m < 16; m++) begin
            cwrite(m, 1'b1, 1'b0, ~4'(m), val(m, 9), "R8");
            pread(m, "R8");
        end
        // R8: byte-write enable high means read, word unchanged
        cwrite(40, 1'b1, 1'b1, 4'b0000, val(40, 3), "R8");
        pread(40, "R8");
        idle("R8");

        // R7: global write overrides lane enables held high
        cwrite(41, 1'b0, 1'b1, 4'b1111, val(41, 5), "R7");
        cwrite(42, 1'b0, 1'b0, 4'b1010, val(42, 5), "R7");
        pread(41, "R7");
        pread(42, "R7");

        // R6: suspend reuses address, mixed with advances
        pread(45, "R6");
        cont(1'b1, 1'b1, '0, "R6");
        cont(1'b1, 1'b1, '0, "R6");
        cont(1'b0, 1'b1, '0, "R6");
        cont(1'b1, 1'b1, '0, "R6");
        idle("R6");

        // R5: write burst via advances, wrapping inside the block, then read back
        cwrite(50, 1'b0, 1'b1, '1, val(50, 6), "R5");
        cont(1'b0, 1'b0, val(51, 6), "R5");
        cont(1'b0, 1'b0, val(48, 6), "R5");
        cont(1'b0, 1'b0, val(49, 6), "R5");
        pread(48, "R5");
        for (int k = 0; k < 3; k++) cont(1'b0, 1'b1, '0, "R5");

        // R2: processor strobe ignores active write controls
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 20, val(20, 12), "R2");
        pread(20, "R2");
        // R11: write the opened burst on a later suspend cycle
        pread(21, "R11");
        cont(1'b1, 1'b0, val(21, 13), "R11");
        pread(21, "R11");
        idle("R11");

        // R1: deselect with strobe and write active writes nothing
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 22, val(22, 14), "R1");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 23, val(23, 14), "R1");
        pread(22, "R1");
        pread(23, "R1");
        idle("R1");
        idle("R1");

        // R10 / R9: latency and asynchronous output gating
        pread(30, "R10");
        check("R10 not yet driven", DATA_W'(dq_oe_o), DATA_W'(0));
        ce_n_i = 1'b1; pstb_n_i = 1'b1;
        oe_n_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 gated off", DATA_W'(dq_oe_o), DATA_W'(0));
        oe_n_i = 1'b0;
        #1;
        check("R9 gated on", DATA_W'(dq_oe_o), DATA_W'(1));
        check("R10 data", dq_o, ref_mem[30]);
        pend_valid = 1'b0; pend_tag = "R1";
        idle("R1");
        idle("R1");

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule